// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers a wide vector of level-sensitive interrupt sources into groups of eight. Each group drives one combined line towards a parent interrupt controller. Every source has its own enable bit. An enabled source that is asserted is pending, and a group line is high while any of its eight pending bits is set. Software never writes the enable bits directly. It sets them through one register and clears them through another, where each 1 in the written word acts on the matching bit and each 0 leaves it alone. This lets separate handlers change different sources without a read-modify-write race.

Groups are packed four to a 32-bit register bank. Group n lives in byte lane (n mod 4) of bank n/4, so source 8n+j maps to bit 8(n mod 4)+j of that bank. Bank k starts at byte offset 0x10·k. Within a bank:

| Offset | Write | Read |
|---|---|---|
| 0x0 | set enables | enables |
| 0x4 | clear enables | enables |
| 0xC | ignored | status |

The register port uses plain one-cycle strobes. It has no back-pressure: every access is accepted in the cycle its strobe is high, and read data appears on the following cycle.

The interrupt inputs pass through a two-flop synchroniser before masking, and the group lines are registered. The number of groups is a parameter. The default is 20 groups, which gives 160 sources in five banks.

Top module: `irq_combiner`

## Requirements
- R1: After reset all enable bits are 0, every `irq_out` bit is 0 and `bus_rdata` is 0.
- R2: A write to offset 0x0 of bank k sets each enable bit whose `bus_wdata` bit is 1. Enable bits whose data bit is 0 keep their value. The change takes effect at the write's clock edge.
- R3: A write to offset 0x4 of bank k clears each enable bit whose `bus_wdata` bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A read of offset 0x0 or 0x4 of bank k returns that bank's 32 enable bits on `bus_rdata` after the edge that samples `bus_rd`. `bus_rdata` holds that value until the next read.
- R5: A read of offset 0xC returns the bank's status. Status bit 8(n mod 4)+j equals synchronised source 8n+j AND its enable bit.
- R6: `irq_out[n]` is the OR of group n's eight status bits, delayed by one register. A source raised before clock edge E shows on its enabled group line after edge E+2. A line already pending behind a cleared enable rises one edge after the set write.
- R7: Sources are level-sensitive. A group line stays high while an enabled source is held, and it falls three edges after the last pending source drops.
- R8: Bank k decodes at byte offset 0x10·k. Group n occupies byte lane n mod 4 of bank n/4, so an access to one bank never changes another bank's enables.
- R9: Writes to offset 0xC, to offsets 0x8 or 0x1–0x3/0x5–0x7/0x9–0xB/0xD–0xF, or to banks at or beyond the group count have no effect. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, data on the next cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 8·NUM_GROUPS | Raw level-sensitive sources |
| irq_out | output | NUM_GROUPS | One combined line per group |

## Verification
The bench clears single bits out of a partly enabled group. A design that treats the clear word as a new value, rather than a bit mask, would lose the remaining enables and drop the group line early. It also writes all-ones to the status offset, to gaps in the map and to a bank past the last one. A decoder that aliases the bank index, or takes 0xC as a set, would change enables that read back as altered. Lane placement is checked with sources in the top byte lane and in the middle lanes of different banks, which exposes a wrong shift or an off-by-one bank. Edge-exact latency checks on source rise, enable set and source fall catch a missing or extra synchroniser or output stage.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int SRC_PER_GRP   = 8;
  localparam int GRP_PER_BANK  = 4;
  localparam int BANK_BITS     = SRC_PER_GRP * GRP_PER_BANK;
  localparam int BANK_STRIDE_LG = 4;

  typedef enum logic [3:0] {
    OFF_SET    = 4'h0,
    OFF_CLR    = 4'h4,
    OFF_STATUS = 4'hC
  } reg_off_e;
endpackage

// File: rtl/irq_comb_sync.sv
module irq_comb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/irq_comb_bank.sv
module irq_comb_bank
  import irq_comb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [BANK_BITS-1:0] wdata,
  input  logic [BANK_BITS-1:0] src,
  output logic [BANK_BITS-1:0] enable,
  output logic [BANK_BITS-1:0] status,
  output logic [LANES-1:0]     grp_irq
);
  localparam int USED = LANES * SRC_PER_GRP;
  localparam logic [BANK_BITS-1:0] LANE_MASK = {BANK_BITS{1'b1}} >> (BANK_BITS - USED);

  logic [BANK_BITS-1:0] en_q;
  logic [LANES-1:0]     grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (set_we) begin
      en_q <= en_q | (wdata & LANE_MASK);
    end else if (clr_we) begin
      en_q <= en_q & ~wdata;
    end
  end

  assign status = src & en_q;
  assign enable = en_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q[l] <= 1'b0;
      else        grp_q[l] <= |status[l*SRC_PER_GRP +: SRC_PER_GRP];
    end

    p_out_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|status[l*SRC_PER_GRP +: SRC_PER_GRP]) |=> grp_irq[l]);
    p_out_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|status[l*SRC_PER_GRP +: SRC_PER_GRP]) |=> !grp_irq[l]);
  end

  assign grp_irq = grp_q;

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((enable & $past(wdata & LANE_MASK)) == $past(wdata & LANE_MASK)));
  p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((enable & $past(enable)) == $past(enable)));
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((enable & $past(wdata)) == '0));
  p_clr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((enable & ~$past(wdata)) == ($past(enable) & ~$past(wdata))));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(enable));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] irq_in,
  output logic [NUM_GROUPS-1:0]             irq_out
);
  localparam int NUM_SRC   = NUM_GROUPS * SRC_PER_GRP;
  localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;
  localparam int PAD_W     = NUM_BANKS * BANK_BITS;
  localparam int BIDX_W    = ADDR_W - BANK_STRIDE_LG;

  logic [NUM_SRC-1:0]    src_sync;
  logic [PAD_W-1:0]      src_pad;
  logic [BIDX_W-1:0]     bank_idx;
  logic [3:0]            reg_off;
  logic                  bank_hit;
  logic [BANK_BITS-1:0]  bank_en [NUM_BANKS];
  logic [BANK_BITS-1:0]  bank_st [NUM_BANKS];
  logic [BANK_BITS-1:0]  rd_mux;
  logic                  rd_hit;
  logic [31:0]           rdata_q;

  irq_comb_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(src_sync)
  );

  assign src_pad  = PAD_W'(src_sync);
  assign bank_idx = bus_addr[ADDR_W-1:BANK_STRIDE_LG];
  assign reg_off  = bus_addr[BANK_STRIDE_LG-1:0];
  assign bank_hit = (32'(bank_idx) < NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LN = ((NUM_GROUPS - b*GRP_PER_BANK) >= GRP_PER_BANK) ?
                        GRP_PER_BANK : (NUM_GROUPS - b*GRP_PER_BANK);
    logic sel;
    assign sel = bank_hit && (32'(bank_idx) == b);

    irq_comb_bank #(.LANES(LN)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (bus_wr && sel && (reg_off == OFF_SET)),
      .clr_we (bus_wr && sel && (reg_off == OFF_CLR)),
      .wdata  (bus_wdata),
      .src    (src_pad[b*BANK_BITS +: BANK_BITS]),
      .enable (bank_en[b]),
      .status (bank_st[b]),
      .grp_irq(irq_out[b*GRP_PER_BANK +: LN])
    );
  end

  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit && (32'(bank_idx) == b)) begin
        if (reg_off == OFF_SET || reg_off == OFF_CLR) begin
          rd_mux = bank_en[b];
          rd_hit = 1'b1;
        end else if (reg_off == OFF_STATUS) begin
          rd_mux = bank_st[b];
          rd_hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> (bus_rdata == '0));
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  p_status_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (reg_off == OFF_STATUS)) |=> $stable(bank_en[0]));

  initial begin
    a_addr_fits_r8: assert (NUM_BANKS <= (1 << BIDX_W));
  end
endmodule

// File: tb/irq_combiner_test.sv
module irq_combiner_test;
  localparam int NG   = 20;
  localparam int NS   = NG * 8;
  localparam int NB   = 5;
  localparam int AW   = 8;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  bank;
    logic [31:0] data;
  } vec_t;

  localparam logic [1:0] OP_SET = 2'd0, OP_CLR = 2'd1, OP_RAW = 2'd2, OP_STW = 2'd3;

  localparam vec_t VECS [13] = '{
    '{OP_SET, 3'd0, 32'h0000_00FF},
    '{OP_RAW, 3'd0, 32'h0000_0081},
    '{OP_RAW, 3'd1, 32'hFFFF_FFFF},
    '{OP_SET, 3'd1, 32'h0100_0000},
    '{OP_CLR, 3'd0, 32'h0000_0001},
    '{OP_CLR, 3'd0, 32'h0000_0080},
    '{OP_SET, 3'd4, 32'hA5A5_A5A5},
    '{OP_RAW, 3'd4, 32'h0F0F_0F0F},
    '{OP_STW, 3'd0, 32'hFFFF_FFFF},
    '{OP_CLR, 3'd4, 32'h00FF_FF00},
    '{OP_SET, 3'd2, 32'hFFFF_FFFF},
    '{OP_RAW, 3'd2, 32'h0000_8000},
    '{OP_CLR, 3'd1, 32'hFFFF_FFFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] irq_in = '0;
  logic [NG-1:0] irq_out;

  logic [NS-1:0] en_m  = '0;
  logic [NS-1:0] raw_m = '0;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [NG-1:0] exp_out();
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = |(raw_m[g*8 +: 8] & en_m[g*8 +: 8]);
    return r;
  endfunction

  task automatic sweep(input string tag);
    logic [31:0] v;
    for (int b = 0; b < NB; b++) begin
      rd(AW'(b * 16), v);
      check({tag, " R4 enable read"}, v, en_m[b*32 +: 32]);
      rd(AW'(b * 16 + 12), v);
      check({tag, " R5 status read"}, v, raw_m[b*32 +: 32] & en_m[b*32 +: 32]);
    end
    rd(AW'(4), v);
    check({tag, " R4 clear-offset read"}, v, en_m[31:0]);
    check({tag, " R6 R8 group lines"}, 32'(irq_out), 32'(exp_out()));
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cycles(2);
    check("R1 out at reset", 32'(irq_out), 32'h0);
    check("R1 rdata at reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    cycles(1);
    irq_in = '1;
    cycles(4);
    check("R1 enables zero so lines low", 32'(irq_out), 32'h0);
    rd(8'h00, v);
    check("R1 enables zero", v, 32'h0);
    irq_in = '0;
    cycles(3);

    for (int i = 0; i < 13; i++) begin
      vec_t t = VECS[i];
      case (t.op)
        OP_SET: begin wr(AW'(t.bank * 16),     t.data); en_m[t.bank*32 +: 32] |= t.data;  end
        OP_CLR: begin wr(AW'(t.bank * 16 + 4), t.data); en_m[t.bank*32 +: 32] &= ~t.data; end
        OP_STW: begin wr(AW'(t.bank * 16 + 12), t.data); end
        default: begin raw_m[t.bank*32 +: 32] = t.data; irq_in = raw_m; end
      endcase
      cycles(3);
      sweep($sformatf("vec%0d R2 R3 R9", i));
    end

    // R9: gaps, offset 0x8 and banks past the end
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF);
    sweep("R9 ignored writes");
    rd(8'h08, v);  check("R9 read gap 0x8", v, 32'h0);
    rd(8'h50, v);  check("R9 read bank past end", v, 32'h0);
    rd(8'h4D, v);  check("R9 read misaligned", v, 32'h0);

    // R6 latency: source rise on enabled group 1 (bank 0 lane 1)
    wr(8'h00, 32'h0000_0100); en_m[8] = 1'b1;
    cycles(3);
    raw_m[8] = 1'b1; irq_in = raw_m;
    cycles(2);
    check("R6 not yet after two edges", 32'(irq_out[1]), 32'h0);
    cycles(1);
    check("R6 high after third edge", 32'(irq_out[1]), 32'h1);

    // R7 level hold and fall
    cycles(10);
    check("R7 held while level held", 32'(irq_out[1]), 32'h1);
    raw_m[8] = 1'b0; irq_in = raw_m;
    cycles(2);
    check("R7 still high two edges after drop", 32'(irq_out[1]), 32'h1);
    cycles(1);
    check("R7 low three edges after drop", 32'(irq_out[1]), 32'h0);

    // R6 enable latency on group 3 (bank 0 lane 3) with source pending
    raw_m[24] = 1'b1; irq_in = raw_m;
    cycles(3);
    check("R6 pending but masked", 32'(irq_out[3]), 32'h0);
    wr(8'h00, 32'h0100_0000); en_m[24] = 1'b1;
    check("R6 not yet at write edge", 32'(irq_out[3]), 32'h0);
    cycles(1);
    check("R6 high one edge after set", 32'(irq_out[3]), 32'h1);
    sweep("final R2 R5");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule